// File: doc/BRIEF.md
# Row-Buffer Aware Request Delay Scheduler

This block models the timing of a single memory rank with one row buffer. It decides when each outstanding elementary access (one beat of a write or read burst) would have finished on a slow memory. Allocation inputs register a burst against an internal identifier: a base address, a beat count, and whether it is a write or a read. The scheduler then serves one beat at a time. Beats that would hit the open row are served before beats on a closed rank, and those before beats that conflict with the open row. Within the chosen class the beat whose burst was allocated earliest wins, and a write wins over a read of equal standing.

Each served beat loads a down-counter with its latency. The beat is marked complete on the clock edge at which that counter reads three, which lets the downstream response path prepare its output. A write identifier raises its release-enable flag once every beat of its burst is complete. A read identifier holds a small count of completed but unreleased beats, and its enable is high while that count is non-zero. Release reports from the response storage lower the write flags and consume the read counts.

Top module: `rowbuf_sched`

## Requirements
- R1: After reset every write and read release-enable output is 0 and no row is open, so the first access is charged as an access to a closed rank.
- R2: A beat costs HIT_COST cycles when its row (address bits above ROW_LOW_W) equals the open row, HIT_COST+ACT_COST when no row is open, and HIT_COST+ACT_COST+PRE_COST when another row is open. A single write beat allocated at clock edge A into an idle scheduler raises its release enable after edge A+cost-1.
- R3: Only one beat is in service at a time. A new beat starts only once the counter has returned to zero, so successive hit beats complete HIT_COST+1 cycles apart.
- R4: Among waiting beats, the lowest cost class (hit, then closed rank, then conflict) is served first, even when a costlier beat is older.
- R5: Within one class, the beat of the earliest allocated burst is served first, regardless of slot index.
- R6: A write beat and a read beat allocated in the same cycle with equal cost class are ordered write first.
- R7: A write release enable rises only when all beats of that write burst are complete, not after earlier beats.
- R8: A write release report on bit i (one-hot wr_released) clears write release enable i one cycle later.
- R9: Each completed read beat adds one to its identifier's count. A read release report subtracts one, and the read release enable is high exactly while the count is non-zero.
- R10: A read beat completion and a read release report for the same identifier in the same cycle leave that count unchanged.
- R11: The length field gives beats minus one. Beats at positions beyond it are never served, so a burst with length field 1 yields exactly two completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_alloc_vld | input | 1 | Register a write burst this cycle |
| wr_alloc_iid | input | $clog2(NUM_WR) | Internal identifier of the write burst |
| wr_alloc_addr | input | ADDR_W | Base byte address of the write burst |
| wr_alloc_len | input | $clog2(MAX_BURST) | Write beats minus one |
| rd_alloc_vld | input | 1 | Register a read burst this cycle |
| rd_alloc_iid | input | $clog2(NUM_RD) | Internal identifier of the read burst |
| rd_alloc_addr | input | ADDR_W | Base byte address of the read burst |
| rd_alloc_len | input | $clog2(MAX_BURST) | Read beats minus one |
| wr_released | input | NUM_WR | One-hot report that a write response left |
| rd_released | input | NUM_RD | One-hot report that a read beat left |
| wr_rel_en | output | NUM_WR | Per-identifier write release enable |
| rd_rel_en | output | NUM_RD | Per-identifier read release enable |

## Verification
Two functions can fall in the same cycle: the completion of a read beat, which increments its identifier's count, and a release report that decrements that same count. The bench allocates a two-beat read hit and drives the release report exactly on the edge where the second beat completes. It then confirms that the enable stays high and that one further report brings it low. A second coincidence is a write and a read allocated on the same edge with equal class and age. The bench judges it by which release enable rises first.

// File: rtl/rowbuf_sched_pkg.sv
// Shared types for the row-buffer delay scheduler.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rowbuf_sched_pkg;

    // Cost class of a beat relative to the rank's row buffer; lower is cheaper.
    typedef enum logic [1:0] {
        CLS_HIT      = 2'd0,
        CLS_EMPTY    = 2'd1,
        CLS_CONFLICT = 2'd2
    } cost_cls_e;

    // Classify a beat from the row-buffer state and a row comparison.
    function automatic cost_cls_e classify(input logic row_open, input logic same_row);
        if (!row_open)     return CLS_EMPTY;
        else if (same_row) return CLS_HIT;
        else               return CLS_CONFLICT;
    endfunction

endpackage

// File: rtl/rowbuf_rank.sv
// Single-rank timing model: latency down-counter plus row-buffer state.
// Assumes start is asserted only while idle is high, and that all costs
// are at least 3 so the completion point (counter == 3) is always reached.
module rowbuf_rank
    import rowbuf_sched_pkg::*;
#(
    parameter int ROW_W    = 22,
    parameter int DELAY_W  = 8,
    parameter int HIT_COST = 4,
    parameter int ACT_COST = 5,
    parameter int PRE_COST = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] start_row,
    output logic             idle,
    output logic             at_done,
    output logic             row_open,
    output logic [ROW_W-1:0] open_row
);

    logic [DELAY_W-1:0] cnt_q;
    cost_cls_e          start_cls;
    logic [DELAY_W-1:0] start_cost;

    // Cost of the beat being started, from its class.
    always_comb begin
        start_cls  = classify(row_open, start_row == open_row);
        start_cost = DELAY_W'(HIT_COST);
        if (start_cls != CLS_HIT)      start_cost = start_cost + DELAY_W'(ACT_COST);
        if (start_cls == CLS_CONFLICT) start_cost = start_cost + DELAY_W'(PRE_COST);
    end

    // Counter loads on start, otherwise counts down and rests at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= start_cost;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - DELAY_W'(1);
        end
    end

    // Row buffer changes only when an access starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            open_row <= '0;
        end else if (start) begin
            row_open <= 1'b1;
            open_row <= start_row;
        end
    end

    assign idle    = (cnt_q == '0);
    assign at_done = (cnt_q == DELAY_W'(3));

endmodule

// File: rtl/rowbuf_pick.sv
// Combinational first-ready selector: lowest cost class, then greatest age.
// Ties keep the lowest index, so callers place writes at lower indices.
module rowbuf_pick
    import rowbuf_sched_pkg::*;
#(
    parameter int N     = 32,
    parameter int SEQ_W = 8,
    localparam int IDX_W = $clog2(N),
    localparam int KEY_W = SEQ_W + 2
) (
    input  logic [N-1:0]     cand,
    input  cost_cls_e        cls [N],
    input  logic [SEQ_W-1:0] age [N],
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic [KEY_W-1:0] best_key;
    logic [KEY_W-1:0] key;

    // Scan candidates, keeping the first strictly better key.
    always_comb begin
        any      = 1'b0;
        idx      = '0;
        best_key = '0;
        key      = '0;
        for (int e = 0; e < N; e++) begin
            key = {2'd3 - 2'(cls[e]), age[e]};
            if (cand[e] && (!any || key > best_key)) begin
                any      = 1'b1;
                idx      = IDX_W'(e);
                best_key = key;
            end
        end
    end

endmodule

// File: rtl/rowbuf_release.sv
// Release-enable state: one flag per write identifier, one beat count per
// read identifier. Assumes at most MAX_BURST unreleased beats per read id.
module rowbuf_release #(
    parameter int NUM_WR    = 4,
    parameter int NUM_RD    = 4,
    parameter int MAX_BURST = 4,
    localparam int CNT_W = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WR-1:0] wr_set,
    input  logic [NUM_WR-1:0] wr_clr,
    input  logic [NUM_RD-1:0] rd_inc,
    input  logic [NUM_RD-1:0] rd_dec,
    output logic [NUM_WR-1:0] wr_en,
    output logic [NUM_RD-1:0] rd_en
);

    for (genvar i = 0; i < NUM_WR; i++) begin : g_wr
        // Write flag: set on burst completion, cleared on release report.
        always_ff @(posedge clk) begin
            if (!rst_n)         wr_en[i] <= 1'b0;
            else if (wr_set[i]) wr_en[i] <= 1'b1;
            else if (wr_clr[i]) wr_en[i] <= 1'b0;
        end
    end

    for (genvar j = 0; j < NUM_RD; j++) begin : g_rd
        logic [CNT_W-1:0] cnt_q;
        // Read count: +1 per completed beat, -1 per release, hold when both.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (rd_inc[j] && !rd_dec[j]) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (rd_dec[j] && !rd_inc[j] && cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
        assign rd_en[j] = (cnt_q != '0);
    end

endmodule

// File: rtl/rowbuf_sched.sv
// Row-buffer delay scheduler top: burst slots, beat selection, completion.
// Slots 0..NUM_WR-1 hold writes, the rest hold reads; a slot is indexed by
// its internal identifier. Allocation into a slot with beats still
// outstanding is dropped. Age is a modular allocation sequence number,
// valid while fewer than 2**(SEQ_W-1) allocations occur in a burst's life.
module rowbuf_sched
    import rowbuf_sched_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ROW_LOW_W = 10,
    parameter int BEAT_LOG  = 3,
    parameter int MAX_BURST = 4,
    parameter int NUM_WR    = 4,
    parameter int NUM_RD    = 4,
    parameter int HIT_COST  = 4,
    parameter int ACT_COST  = 5,
    parameter int PRE_COST  = 6,
    parameter int DELAY_W   = 8,
    parameter int SEQ_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_alloc_vld,
    input  logic [$clog2(NUM_WR)-1:0]    wr_alloc_iid,
    input  logic [ADDR_W-1:0]            wr_alloc_addr,
    input  logic [$clog2(MAX_BURST)-1:0] wr_alloc_len,
    input  logic                         rd_alloc_vld,
    input  logic [$clog2(NUM_RD)-1:0]    rd_alloc_iid,
    input  logic [ADDR_W-1:0]            rd_alloc_addr,
    input  logic [$clog2(MAX_BURST)-1:0] rd_alloc_len,
    input  logic [NUM_WR-1:0]            wr_released,
    input  logic [NUM_RD-1:0]            rd_released,
    output logic [NUM_WR-1:0]            wr_rel_en,
    output logic [NUM_RD-1:0]            rd_rel_en
);

    localparam int TOT    = NUM_WR + NUM_RD;
    localparam int N      = TOT * MAX_BURST;
    localparam int SLOT_W = $clog2(TOT);
    localparam int BEAT_W = $clog2(MAX_BURST);
    localparam int IDX_W  = $clog2(N);
    localparam int ROW_W  = ADDR_W - ROW_LOW_W;

    logic [MAX_BURST-1:0] slot_done [TOT];
    logic [ADDR_W-1:0]    slot_base [TOT];
    logic [SEQ_W-1:0]     slot_seq  [TOT];
    logic [SEQ_W-1:0]     seq_ctr;
    logic                 pend_vld;
    logic [SLOT_W-1:0]    pend_slot;
    logic [BEAT_W-1:0]    pend_beat;

    logic [N-1:0]         cand;
    cost_cls_e            ent_cls [N];
    logic [SEQ_W-1:0]     ent_age [N];
    logic [ROW_W-1:0]     ent_row [N];

    logic                 pick_any;
    logic [IDX_W-1:0]     pick_idx;
    logic                 start;
    logic                 rank_idle;
    logic                 at_done;
    logic                 row_open;
    logic [ROW_W-1:0]     open_row;
    logic [NUM_WR-1:0]    wr_set;
    logic [NUM_RD-1:0]    rd_inc;
    logic [MAX_BURST-1:0] beat_oh;
    logic [SLOT_W-1:0]    wr_slot;
    logic [SLOT_W-1:0]    rd_slot;

    // Done mask at allocation: positions beyond the length are pre-completed.
    function automatic logic [MAX_BURST-1:0] init_done(input logic [BEAT_W-1:0] len);
        logic [MAX_BURST-1:0] m;
        for (int b = 0; b < MAX_BURST; b++) m[b] = (b > int'(len));
        return m;
    endfunction

    assign wr_slot = SLOT_W'(wr_alloc_iid);
    assign rd_slot = SLOT_W'(NUM_WR) + SLOT_W'(rd_alloc_iid);

    // Per-beat view: row, class, age and eligibility.
    for (genvar e = 0; e < N; e++) begin : g_ent
        localparam int S = e / MAX_BURST;
        localparam int B = e % MAX_BURST;
        assign ent_row[e] = ROW_W'((slot_base[S] + ADDR_W'(B << BEAT_LOG)) >> ROW_LOW_W);
        assign ent_cls[e] = classify(row_open, ent_row[e] == open_row);
        assign ent_age[e] = seq_ctr - slot_seq[S];
        assign cand[e]    = !slot_done[S][B] &&
                            !(pend_vld && pend_slot == SLOT_W'(S) && pend_beat == BEAT_W'(B));
    end

    rowbuf_pick #(.N(N), .SEQ_W(SEQ_W)) u_pick (
        .cand (cand),
        .cls  (ent_cls),
        .age  (ent_age),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    assign start = rank_idle && pick_any;

    rowbuf_rank #(
        .ROW_W(ROW_W), .DELAY_W(DELAY_W),
        .HIT_COST(HIT_COST), .ACT_COST(ACT_COST), .PRE_COST(PRE_COST)
    ) u_rank (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_row (ent_row[pick_idx]),
        .idle      (rank_idle),
        .at_done   (at_done),
        .row_open  (row_open),
        .open_row  (open_row)
    );

    // Slot storage, sequence counter and the in-service beat record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < TOT; s++) begin
                slot_done[s] <= '1;
                slot_base[s] <= '0;
                slot_seq[s]  <= '0;
            end
            seq_ctr   <= '0;
            pend_vld  <= 1'b0;
            pend_slot <= '0;
            pend_beat <= '0;
        end else begin
            if (start) begin
                pend_vld  <= 1'b1;
                pend_slot <= SLOT_W'(pick_idx / IDX_W'(MAX_BURST));
                pend_beat <= BEAT_W'(pick_idx % IDX_W'(MAX_BURST));
            end else if (at_done && pend_vld) begin
                pend_vld <= 1'b0;
                slot_done[pend_slot][pend_beat] <= 1'b1;
            end
            if (wr_alloc_vld && (&slot_done[wr_slot])) begin
                slot_done[wr_slot] <= init_done(wr_alloc_len);
                slot_base[wr_slot] <= wr_alloc_addr;
                slot_seq[wr_slot]  <= seq_ctr;
            end
            if (rd_alloc_vld && (&slot_done[rd_slot])) begin
                slot_done[rd_slot] <= init_done(rd_alloc_len);
                slot_base[rd_slot] <= rd_alloc_addr;
                slot_seq[rd_slot]  <= seq_ctr;
            end
            if (wr_alloc_vld || rd_alloc_vld) seq_ctr <= seq_ctr + SEQ_W'(1);
        end
    end

    assign beat_oh = MAX_BURST'(1) << pend_beat;

    // Completion events routed to the release-enable state.
    for (genvar i = 0; i < NUM_WR; i++) begin : g_wset
        assign wr_set[i] = at_done && pend_vld && pend_slot == SLOT_W'(i) &&
                           (&(slot_done[i] | beat_oh));
    end
    for (genvar j = 0; j < NUM_RD; j++) begin : g_rinc
        assign rd_inc[j] = at_done && pend_vld && pend_slot == SLOT_W'(NUM_WR + j);
    end

    rowbuf_release #(.NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .MAX_BURST(MAX_BURST)) u_rel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_set (wr_set),
        .wr_clr (wr_released),
        .rd_inc (rd_inc),
        .rd_dec (rd_released),
        .wr_en  (wr_rel_en),
        .rd_en  (rd_rel_en)
    );

endmodule

// File: rtl/rowbuf_sched_chk.sv
// Assertion checker for rowbuf_sched, attached by bind below.
// Observes the start/idle handshake with the rank and the release state.
module rowbuf_sched_chk #(
    parameter int NUM_WR = 4,
    parameter int NUM_RD = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rank_idle,
    input logic              pend_vld,
    input logic [NUM_WR-1:0] wr_set,
    input logic [NUM_WR-1:0] wr_released,
    input logic [NUM_WR-1:0] wr_rel_en,
    input logic [NUM_RD-1:0] rd_inc,
    input logic [NUM_RD-1:0] rd_released,
    input logic [NUM_RD-1:0] rd_rel_en
);

    // R3: a started beat keeps the rank busy on the next cycle.
    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !rank_idle);

    // R3: a beat in service means the counter is not at rest.
    a_r3_pend_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld |-> !rank_idle);

    for (genvar i = 0; i < NUM_WR; i++) begin : g_w
        // R7: a completed write burst raises its enable.
        a_r7_wr_raise: assert property (@(posedge clk) disable iff (!rst_n)
            wr_set[i] |=> wr_rel_en[i]);
        // R8: a release report clears the write enable.
        a_r8_wr_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_released[i] && !wr_set[i]) |=> !wr_rel_en[i]);
    end

    for (genvar j = 0; j < NUM_RD; j++) begin : g_r
        // R10: simultaneous completion and release keep the read enable.
        a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_inc[j] && rd_released[j]) |=> $stable(rd_rel_en[j]));
        // R9: a completed read beat makes the read enable high.
        a_r9_rd_raise: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_inc[j] && !rd_released[j]) |=> rd_rel_en[j]);
    end

endmodule

bind rowbuf_sched rowbuf_sched_chk #(.NUM_WR(NUM_WR), .NUM_RD(NUM_RD)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rank_idle   (rank_idle),
    .pend_vld    (pend_vld),
    .wr_set      (wr_set),
    .wr_released (wr_released),
    .wr_rel_en   (wr_rel_en),
    .rd_inc      (rd_inc),
    .rd_released (rd_released),
    .rd_rel_en   (rd_rel_en)
);

// File: tb/sim_rowbuf_sched.sv
// Directed bench for rowbuf_sched: one task per scenario.
module sim_rowbuf_sched;

    localparam int HIT = 4, ACT = 5, PRE = 6;
    localparam logic [31:0] ROWA = 32'h0000_1000;
    localparam logic [31:0] ROWB = 32'h0000_2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wv = 0, rv = 0;
    logic [1:0] wiid = 0, riid = 0, wlen = 0, rlen = 0;
    logic [31:0] waddr = 0, raddr = 0;
    logic [3:0] wrel = 0, rrel = 0;
    logic [3:0] wen, ren;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    rowbuf_sched u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_alloc_vld(wv), .wr_alloc_iid(wiid), .wr_alloc_addr(waddr), .wr_alloc_len(wlen),
        .rd_alloc_vld(rv), .rd_alloc_iid(riid), .rd_alloc_addr(raddr), .rd_alloc_len(rlen),
        .wr_released(wrel), .rd_released(rrel),
        .wr_rel_en(wen), .rd_rel_en(ren)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one allocation cycle; returns at the negedge after that edge.
    task automatic alloc(input logic w, input logic [1:0] wi, input logic [31:0] wa,
                         input logic [1:0] wl, input logic r, input logic [1:0] ri,
                         input logic [31:0] ra, input logic [1:0] rl);
        wv = w; wiid = wi; waddr = wa; wlen = wl;
        rv = r; riid = ri; raddr = ra; rlen = rl;
        @(negedge clk);
        wv = 0; rv = 0;
    endtask

    task automatic release_ids(input logic [3:0] wm, input logic [3:0] rm);
        wrel = wm; rrel = rm;
        @(negedge clk);
        wrel = 0; rrel = 0;
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    // Edges from the allocation edge until write enable bit rises.
    task automatic wr_latency(input int b, output int k);
        k = -1;
        for (int n = 1; n <= 100; n++) begin
            @(negedge clk);
            if (wen[b]) begin k = n; break; end
        end
    endtask

    task automatic t_reset();
        chk("R1 write enables after reset", int'(wen), 0);
        chk("R1 read enables after reset", int'(ren), 0);
    endtask

    task automatic t_closed_rank();
        int k;
        alloc(1, 0, ROWA, 0, 0, 0, 0, 0);
        wr_latency(0, k);
        chk("R1 R2 closed-rank latency", k, HIT + ACT - 1);
        release_ids(4'b0001, 0);
        chk("R8 write enable cleared", int'(wen[0]), 0);
        settle();
    endtask

    task automatic t_hit();
        int k;
        alloc(1, 1, ROWA + 32'h40, 0, 0, 0, 0, 0);
        wr_latency(1, k);
        chk("R2 row-hit latency", k, HIT - 1);
        release_ids(4'b0010, 0);
        settle();
    endtask

    task automatic t_conflict();
        int k;
        alloc(1, 2, ROWB, 0, 0, 0, 0, 0);
        wr_latency(2, k);
        chk("R2 row-conflict latency", k, HIT + ACT + PRE - 1);
        release_ids(4'b0100, 0);
        settle();
    endtask

    task automatic t_wr_burst();
        alloc(1, 3, ROWB + 32'h10, 1, 0, 0, 0, 0);
        repeat (7) @(negedge clk);
        chk("R7 write enable low before last beat", int'(wen[3]), 0);
        @(negedge clk);
        chk("R3 R7 write enable after second beat", int'(wen[3]), 1);
        release_ids(4'b1000, 0);
        settle();
    endtask

    task automatic t_rd_count();
        alloc(0, 0, 0, 0, 1, 0, ROWB + 32'h20, 1);
        repeat (3) @(negedge clk);
        chk("R9 read enable after first beat", int'(ren[0]), 1);
        repeat (4) @(negedge clk);
        rrel = 4'b0001;
        @(negedge clk);
        rrel = 0;
        chk("R10 completion and release same cycle", int'(ren[0]), 1);
        release_ids(0, 4'b0001);
        chk("R9 read enable after last release", int'(ren[0]), 0);
        repeat (12) @(negedge clk);
        chk("R11 no beat beyond length", int'(ren[0]), 0);
        settle();
    endtask

    task automatic t_cost_order();
        int ty = -1, tx = -1;
        alloc(1, 0, ROWA, 0, 0, 0, 0, 0);
        alloc(0, 0, 0, 0, 1, 1, ROWB, 0);
        alloc(1, 1, ROWA + 32'h80, 0, 0, 0, 0, 0);
        for (int n = 1; n <= 100; n++) begin
            @(negedge clk);
            if (ty < 0 && wen[1]) ty = n;
            if (tx < 0 && ren[1]) tx = n;
            if (ty >= 0 && tx >= 0) break;
        end
        chk("R4 hit served before older conflict", int'(ty >= 0 && tx >= 0 && ty < tx), 1);
        release_ids(4'b0011, 4'b0010);
        settle();
    endtask

    task automatic t_age_order();
        int tp = -1, tq = -1;
        alloc(1, 0, ROWB, 0, 0, 0, 0, 0);
        alloc(1, 2, ROWB + 32'h100, 0, 0, 0, 0, 0);
        alloc(1, 1, ROWB + 32'h200, 0, 0, 0, 0, 0);
        for (int n = 1; n <= 100; n++) begin
            @(negedge clk);
            if (tp < 0 && wen[2]) tp = n;
            if (tq < 0 && wen[1]) tq = n;
            if (tp >= 0 && tq >= 0) break;
        end
        chk("R5 older burst served first", int'(tp >= 0 && tq >= 0 && tp < tq), 1);
        chk("R3 hit beat spacing", tq - tp, HIT + 1);
        release_ids(4'b0111, 0);
        settle();
    endtask

    task automatic t_write_tie();
        int tw = -1, tr = -1;
        alloc(1, 0, ROWB, 0, 0, 0, 0, 0);
        alloc(1, 3, ROWB + 32'h30, 0, 1, 2, ROWB + 32'h38, 0);
        for (int n = 1; n <= 100; n++) begin
            @(negedge clk);
            if (tw < 0 && wen[3]) tw = n;
            if (tr < 0 && ren[2]) tr = n;
            if (tw >= 0 && tr >= 0) break;
        end
        chk("R6 write wins tie", int'(tw >= 0 && tr >= 0 && tw < tr), 1);
        release_ids(4'b1001, 4'b0100);
        settle();
        chk("R8 R9 all enables idle at end", int'({wen, ren}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_closed_rank();
        t_hit();
        t_conflict();
        t_wr_burst();
        t_rd_count();
        t_cost_order();
        t_age_order();
        t_write_tie();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule